// File: doc/BRIEF.md
# Packed Integer Arithmetic and Compare Unit

This unit is a 64-bit packed integer datapath with one cycle of latency. Each accepted beat carries two 64-bit operands and an 8-bit operation code, and produces one 64-bit result. The operation code is the byte that follows the 0x0F escape in a two-byte opcode; the caller strips the escape byte before presenting it. The lane width, the overflow policy and the kind of operation all come from that single byte.

The operations are lane-wise add and subtract, each with one of three overflow policies: wrap-around, signed clamping or unsigned clamping. There are also signed 16-bit multiplies that keep either half of each product, a multiply that sums adjacent product pairs into 32-bit lanes, and lane-wise equality and signed greater-than compares that return masks. A code outside the supported set yields a zero result and an illegal flag on the same beat.

Both edges of the unit are valid/ready streams. A beat moves when valid and ready are both high at a rising clock edge. The output stage holds one beat. While it is full and the consumer holds `res_ready` low, the result stays frozen and `op_ready` stays low, so the producer must keep its beat asserted. When the consumer takes the result, a new beat can be accepted on the same edge.

Top module: `simd_sat_alu`

## Requirements
- R1: Codes 0xFC, 0xFD and 0xFE add with wrap-around on 8-, 16- and 32-bit lanes. Codes 0xF8, 0xF9 and 0xFA subtract (operand A minus operand B) with wrap-around on the same three lane widths.
- R2: Codes 0xEC and 0xED add, and 0xE8 and 0xE9 subtract, on 8- and 16-bit signed lanes. A lane that overflows takes the most positive value (0x7F / 0x7FFF), and a lane that underflows takes the most negative value (0x80 / 0x8000).
- R3: Codes 0xDC and 0xDD add, and 0xD8 and 0xD9 subtract, on 8- and 16-bit unsigned lanes. A lane that overflows becomes all ones, and a lane that underflows becomes zero.
- R4: Code 0xD5 returns the low 16 bits of each signed 16x16 lane product. Code 0xE5 returns the high 16 bits of each product.
- R5: Code 0xF5 multiplies the signed 16-bit lanes. Lane products 0 and 1 are summed into result bits 31:0, and lane products 2 and 3 are summed into bits 63:32.
- R6: Codes 0x74, 0x75 and 0x76 compare 8-, 16- and 32-bit lanes for equality. Each lane is written as all ones when the operands are equal and as all zeros otherwise.
- R7: Codes 0x64, 0x65 and 0x66 compare 8-, 16- and 32-bit lanes as signed values. A lane is all ones when A is greater than B and all zeros otherwise.
- R8: Any other code produces a zero result with `res_illegal` high on that beat. Every supported code produces `res_illegal` low.
- R9: A beat accepted at one edge appears on `res_valid` and `res_data` after that edge. When the result is taken and no new beat arrives, `res_valid` is low after the next edge.
- R10: While `res_valid` is high and `res_ready` is low, `op_ready` is low and `res_data` and `res_illegal` hold their values.
- R11: After reset, `res_valid` is low and `op_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Input beat present |
| op_ready | output | 1 | Unit can take a beat this cycle |
| op_code | input | 8 | Operation byte following the 0x0F escape |
| op_a | input | 64 | First operand (minuend for subtract) |
| op_b | input | 64 | Second operand |
| res_valid | output | 1 | Result beat present |
| res_ready | input | 1 | Consumer takes the result this cycle |
| res_data | output | 64 | Packed result |
| res_illegal | output | 1 | Operation code was not recognised |

## Verification
A result is due on the first rising edge after its beat is accepted. The bench drives inputs on the falling edge, lets one rising edge pass, and samples `res_valid`, `res_data` and `res_illegal` on the next falling edge. In the back-pressure scenario the frozen result and the low `op_ready` are checked on each stalled falling edge. The next result is then expected on the falling edge after `res_ready` rises, because the release and the new acceptance happen on the same rising edge. One further edge later, the drained state is checked.

// File: rtl/simd_pkg.sv
package simd_pkg;

  typedef enum logic [1:0] {
    SAT_WRAP     = 2'd0,
    SAT_SIGNED   = 2'd1,
    SAT_UNSIGNED = 2'd2
  } sat_mode_e;

  typedef enum logic [1:0] {
    LW_8  = 2'd0,
    LW_16 = 2'd1,
    LW_32 = 2'd2
  } lane_w_e;

  typedef enum logic [2:0] {
    FN_ARITH  = 3'd0,
    FN_MUL_LO = 3'd1,
    FN_MUL_HI = 3'd2,
    FN_MADD   = 3'd3,
    FN_EQ     = 3'd4,
    FN_GT     = 3'd5
  } fn_e;

  typedef struct packed {
    logic      legal;
    logic      sub;
    sat_mode_e mode;
    lane_w_e   width;
    fn_e       fn;
  } op_dec_t;

  function automatic op_dec_t decode_op(input logic [7:0] code);
    op_dec_t d;
    d.legal = 1'b1;
    d.sub   = 1'b0;
    d.mode  = SAT_WRAP;
    d.width = LW_8;
    d.fn    = FN_ARITH;
    case (code)
      8'hFC: d.width = LW_8;
      8'hFD: d.width = LW_16;
      8'hFE: d.width = LW_32;
      8'hF8: begin d.sub = 1'b1; d.width = LW_8;  end
      8'hF9: begin d.sub = 1'b1; d.width = LW_16; end
      8'hFA: begin d.sub = 1'b1; d.width = LW_32; end
      8'hEC: begin d.mode = SAT_SIGNED; d.width = LW_8;  end
      8'hED: begin d.mode = SAT_SIGNED; d.width = LW_16; end
      8'hE8: begin d.mode = SAT_SIGNED; d.sub = 1'b1; d.width = LW_8;  end
      8'hE9: begin d.mode = SAT_SIGNED; d.sub = 1'b1; d.width = LW_16; end
      8'hDC: begin d.mode = SAT_UNSIGNED; d.width = LW_8;  end
      8'hDD: begin d.mode = SAT_UNSIGNED; d.width = LW_16; end
      8'hD8: begin d.mode = SAT_UNSIGNED; d.sub = 1'b1; d.width = LW_8;  end
      8'hD9: begin d.mode = SAT_UNSIGNED; d.sub = 1'b1; d.width = LW_16; end
      8'hD5: begin d.fn = FN_MUL_LO; d.width = LW_16; end
      8'hE5: begin d.fn = FN_MUL_HI; d.width = LW_16; end
      8'hF5: begin d.fn = FN_MADD;   d.width = LW_32; end
      8'h74: begin d.fn = FN_EQ; d.width = LW_8;  end
      8'h75: begin d.fn = FN_EQ; d.width = LW_16; end
      8'h76: begin d.fn = FN_EQ; d.width = LW_32; end
      8'h64: begin d.fn = FN_GT; d.width = LW_8;  end
      8'h65: begin d.fn = FN_GT; d.width = LW_16; end
      8'h66: begin d.fn = FN_GT; d.width = LW_32; end
      default: d.legal = 1'b0;
    endcase
    return d;
  endfunction

endpackage

// File: rtl/simd_lane_arith.sv
module simd_lane_arith
  import simd_pkg::*;
#(
  parameter int DW = 64,
  parameter int LW = 8
) (
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  input  logic          sub,
  input  sat_mode_e     mode,
  output logic [DW-1:0] res
);
  localparam int NL = DW / LW;
  localparam logic [LW-1:0] SMAX = {1'b0, {(LW-1){1'b1}}};
  localparam logic [LW-1:0] SMIN = {1'b1, {(LW-1){1'b0}}};

  for (genvar i = 0; i < NL; i++) begin : g_lane
    logic [LW-1:0] la, lb, r;
    logic [LW:0]   usum, ssum;
    logic          sovf;

    assign la = a[i*LW +: LW];
    assign lb = b[i*LW +: LW];

    always_comb begin
      usum = sub ? ({1'b0, la} - {1'b0, lb}) : ({1'b0, la} + {1'b0, lb});
      ssum = sub ? ({la[LW-1], la} - {lb[LW-1], lb})
                 : ({la[LW-1], la} + {lb[LW-1], lb});
      sovf = ssum[LW] ^ ssum[LW-1];
      case (mode)
        SAT_SIGNED:   r = sovf ? (ssum[LW] ? SMIN : SMAX) : ssum[LW-1:0];
        SAT_UNSIGNED: r = usum[LW] ? (sub ? '0 : '1) : usum[LW-1:0];
        default:      r = ssum[LW-1:0];
      endcase
    end

    assign res[i*LW +: LW] = r;

    always_comb begin
      if (mode == SAT_UNSIGNED && !sub)
        AST_USAT_ADD_NO_DROP: assert (r >= la);  // R3
      if (mode == SAT_UNSIGNED && sub)
        AST_USAT_SUB_NO_RISE: assert (r <= la);  // R3
    end
  end

endmodule

// File: rtl/simd_lane_cmp.sv
module simd_lane_cmp #(
  parameter int DW = 64,
  parameter int LW = 8
) (
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  output logic [DW-1:0] eq_mask,
  output logic [DW-1:0] gt_mask
);
  localparam int NL = DW / LW;

  for (genvar i = 0; i < NL; i++) begin : g_lane
    logic signed [LW-1:0] sa, sb;
    logic is_eq, is_gt;

    assign sa    = a[i*LW +: LW];
    assign sb    = b[i*LW +: LW];
    assign is_eq = (sa == sb);
    assign is_gt = (sa > sb);
    assign eq_mask[i*LW +: LW] = {LW{is_eq}};
    assign gt_mask[i*LW +: LW] = {LW{is_gt}};

    always_comb begin
      AST_CMP_EXCLUSIVE: assert (!(eq_mask[i*LW] && gt_mask[i*LW]));  // R7
    end
  end

endmodule

// File: rtl/simd_mul16.sv
module simd_mul16 #(
  parameter int DW = 64
) (
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  output logic [DW-1:0] lo,
  output logic [DW-1:0] hi,
  output logic [DW-1:0] madd
);
  localparam int NL = DW / 16;
  localparam int NP = NL / 2;

  logic [NL-1:0][31:0] prod;

  for (genvar i = 0; i < NL; i++) begin : g_mul
    logic signed [15:0] sa, sb;
    logic signed [31:0] p;
    assign sa = a[i*16 +: 16];
    assign sb = b[i*16 +: 16];
    assign p  = sa * sb;
    assign prod[i] = p;
    assign lo[i*16 +: 16] = p[15:0];
    assign hi[i*16 +: 16] = p[31:16];
  end

  for (genvar j = 0; j < NP; j++) begin : g_pair
    assign madd[j*32 +: 32] = prod[2*j] + prod[2*j+1];
  end

endmodule

// File: rtl/simd_sat_alu.sv
module simd_sat_alu
  import simd_pkg::*;
#(
  parameter int DW = 64
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          op_valid,
  output logic          op_ready,
  input  logic [7:0]    op_code,
  input  logic [DW-1:0] op_a,
  input  logic [DW-1:0] op_b,
  output logic          res_valid,
  input  logic          res_ready,
  output logic [DW-1:0] res_data,
  output logic          res_illegal
);
  localparam int NW = 3;

  op_dec_t dec;
  assign dec = decode_op(op_code);

  logic [NW-1:0][DW-1:0] arith_res, eq_res, gt_res;
  logic [DW-1:0] mul_lo, mul_hi, mul_madd;

  for (genvar g = 0; g < NW; g++) begin : g_width
    simd_lane_arith #(.DW(DW), .LW(8 << g)) u_arith (
      .a(op_a), .b(op_b), .sub(dec.sub), .mode(dec.mode), .res(arith_res[g])
    );
    simd_lane_cmp #(.DW(DW), .LW(8 << g)) u_cmp (
      .a(op_a), .b(op_b), .eq_mask(eq_res[g]), .gt_mask(gt_res[g])
    );
  end

  simd_mul16 #(.DW(DW)) u_mul (
    .a(op_a), .b(op_b), .lo(mul_lo), .hi(mul_hi), .madd(mul_madd)
  );

  logic [DW-1:0] next_data;

  always_comb begin
    next_data = '0;
    if (dec.legal) begin
      case (dec.fn)
        FN_ARITH:  next_data = arith_res[dec.width];
        FN_MUL_LO: next_data = mul_lo;
        FN_MUL_HI: next_data = mul_hi;
        FN_MADD:   next_data = mul_madd;
        FN_EQ:     next_data = eq_res[dec.width];
        FN_GT:     next_data = gt_res[dec.width];
        default:   next_data = '0;
      endcase
    end
  end

  assign op_ready = !res_valid || res_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_valid   <= 1'b0;
      res_data    <= '0;
      res_illegal <= 1'b0;
    end else if (op_ready) begin
      res_valid <= op_valid;
      if (op_valid) begin
        res_data    <= next_data;
        res_illegal <= !dec.legal;
      end
    end
  end

  AST_ACCEPT_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid && op_ready |=> res_valid);  // R9
  AST_DRAIN_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && res_ready && !op_valid |=> !res_valid);  // R9
  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && !res_ready |=> res_valid && $stable(res_data) && $stable(res_illegal));  // R10
  AST_ILLEGAL_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && res_illegal |-> res_data == '0);  // R8

endmodule

// File: tb/tb_simd_sat_alu.sv
`timescale 1ns/1ps
module tb_simd_sat_alu;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        op_valid = 1'b0;
  logic        op_ready;
  logic [7:0]  op_code = '0;
  logic [63:0] op_a = '0, op_b = '0;
  logic        res_valid;
  logic        res_ready = 1'b1;
  logic [63:0] res_data;
  logic        res_illegal;

  int total = 0;
  int bad = 0;

  always #2 clk = ~clk;

  simd_sat_alu dut (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_ready(op_ready),
    .op_code(op_code), .op_a(op_a), .op_b(op_b), .res_valid(res_valid),
    .res_ready(res_ready), .res_data(res_data), .res_illegal(res_illegal)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic run_op(input string req, input logic [7:0] code,
                        input logic [63:0] a, input logic [63:0] b,
                        input logic [63:0] exp, input logic exp_ill);
    @(negedge clk);
    res_ready = 1'b1;
    op_valid  = 1'b1;
    op_code   = code;
    op_a      = a;
    op_b      = b;
    @(negedge clk);
    op_valid = 1'b0;
    check({req, " valid"}, {63'd0, res_valid}, 64'd1);
    check({req, " data"}, res_data, exp);
    check({req, " illegal"}, {63'd0, res_illegal}, {63'd0, exp_ill});
  endtask

  task automatic t_reset();
    check("R11 res_valid", {63'd0, res_valid}, 64'd0);
    check("R11 op_ready", {63'd0, op_ready}, 64'd1);
  endtask

  task automatic t_wrap();
    run_op("R1 add8",  8'hFC, 64'h01FF_7F80_0010_2030, 64'h0101_0180_00F0_1010, 64'h0200_8000_0000_3040, 1'b0);
    run_op("R1 add16", 8'hFD, 64'hFFFF_0001_8000_1234, 64'h0001_FFFF_8000_1111, 64'h0000_0000_0000_2345, 1'b0);
    run_op("R1 add32", 8'hFE, 64'hFFFF_FFFF_0000_0005, 64'h0000_0001_0000_0003, 64'h0000_0000_0000_0008, 1'b0);
    run_op("R1 sub8",  8'hF8, 64'h0010_8005_0000_0000, 64'h0101_0106_0000_0000, 64'hFF0F_7FFF_0000_0000, 1'b0);
    run_op("R1 sub32", 8'hFA, 64'h0000_0000_0000_0005, 64'h0000_0001_0000_0007, 64'hFFFF_FFFF_FFFF_FFFE, 1'b0);
  endtask

  task automatic t_signed_sat();
    run_op("R2 add8",  8'hEC, 64'h7F80_10F0_0000_0000, 64'h0180_2010_0000_0000, 64'h7F80_3000_0000_0000, 1'b0);
    run_op("R2 sub16", 8'hE9, 64'h8000_7FFF_0005_0000, 64'h0001_FFFF_0007_0000, 64'h8000_7FFF_FFFE_0000, 1'b0);
  endtask

  task automatic t_unsigned_sat();
    run_op("R3 add8",  8'hDC, 64'hFF80_1000_0000_0000, 64'h0180_2000_0000_0000, 64'hFFFF_3000_0000_0000, 1'b0);
    run_op("R3 sub16", 8'hD9, 64'h0005_FFFF_0000_0000, 64'h0007_0001_0000_0000, 64'h0000_FFFE_0000_0000, 1'b0);
  endtask

  task automatic t_mul();
    run_op("R4 mul lo", 8'hD5, 64'h0003_FFFF_0100_0000, 64'h0004_0002_0100_0000, 64'h000C_FFFE_0000_0000, 1'b0);
    run_op("R4 mul hi", 8'hE5, 64'h0003_FFFF_0100_0000, 64'h0004_0002_0100_0000, 64'h0000_FFFF_0001_0000, 1'b0);
    run_op("R5 madd",   8'hF5, 64'h0002_0003_FFFF_8000, 64'h0004_0005_0001_8000, 64'h0000_0017_3FFF_FFFF, 1'b0);
  endtask

  task automatic t_compare();
    run_op("R6 eq8",  8'h74, 64'h0102_0304_0506_0708, 64'h0100_0304_0006_0708, 64'hFF00_FFFF_00FF_FFFF, 1'b0);
    run_op("R6 eq32", 8'h76, 64'h1234_5678_0000_0000, 64'h1234_5678_0000_0001, 64'hFFFF_FFFF_0000_0000, 1'b0);
    run_op("R7 gt8",  8'h64, 64'h807F_0100_FF00_0505, 64'h7F80_0001_00FF_0504, 64'h00FF_FF00_00FF_00FF, 1'b0);
    run_op("R7 gt16", 8'h65, 64'h8000_0001_0000_0000, 64'h0001_8000_0000_0000, 64'h0000_FFFF_0000_0000, 1'b0);
    run_op("R7 gt32", 8'h66, 64'h0000_0000_FFFF_FFFF, 64'hFFFF_FFFF_0000_0000, 64'hFFFF_FFFF_0000_0000, 1'b0);
  endtask

  task automatic t_illegal();
    run_op("R8 code 6F", 8'h6F, 64'h1111_2222_3333_4444, 64'h5555_6666_7777_8888, 64'h0, 1'b1);
    run_op("R8 code EE", 8'hEE, 64'hFFFF_FFFF_FFFF_FFFF, 64'h1, 64'h0, 1'b1);
  endtask

  task automatic t_backpressure();
    @(negedge clk);
    res_ready = 1'b0;
    op_valid  = 1'b1;
    op_code   = 8'hFD;
    op_a      = 64'h0001_0001_0001_0001;
    op_b      = 64'h0001_0001_0001_0001;
    @(negedge clk);
    op_code = 8'hFE;
    op_a    = 64'h0000_0001_0000_0001;
    op_b    = 64'h0000_0002_0000_0002;
    for (int k = 0; k < 3; k++) begin
      check("R10 stall valid", {63'd0, res_valid}, 64'd1);
      check("R10 stall data", res_data, 64'h0002_0002_0002_0002);
      check("R10 stall op_ready", {63'd0, op_ready}, 64'd0);
      @(negedge clk);
    end
    res_ready = 1'b1;
    @(negedge clk);
    op_valid = 1'b0;
    check("R9 next after release", res_data, 64'h0000_0003_0000_0003);
    check("R9 valid after release", {63'd0, res_valid}, 64'd1);
    @(negedge clk);
    check("R9 drained", {63'd0, res_valid}, 64'd0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_wrap();
    t_signed_sat();
    t_unsigned_sat();
    t_mul();
    t_compare();
    t_illegal();
    t_backpressure();
    repeat (2) @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule